// File: doc/BRIEF.md
# Opcode-Driven Status Flag Unit

This block is the status register of a small processor core. It holds twelve flags: four condition flags (zero, negative, carry, overflow), four user flags, three control flags (debug, interrupt enable, sound interrupt enable) and a halt flag. The flags change when the core presents a decoded flag opcode with a valid strobe. Some opcodes set or clear one named flag. Others use a 16-bit mask operand to set, clear or test groups of flags. A dedicated halt opcode raises the halt flag, which stops the core.

The ALU has its own update path. A write-enable, a per-flag select and a value vector let compare, shift and rotate results load the zero, negative, carry and overflow flags. The block drives the whole flag word and also one output line per flag.

Top module: `status_flag_unit`

## Requirements
- R1: An active-low reset clears every flag to zero.
- R2: With the valid strobe high, opcodes 0xA0..0xAA each set one flag. Opcode 0xA0+k sets bit k, and the bits are Z=0, N=1, C=2, V=3, E=4, F=5, B=6, U=7, D=8, I=9, S=10. All other flags keep their values.
- R3: Opcodes 0xAB..0xB5 each clear one flag. Opcode 0xAB+k clears bit k, using the same bit order as R2. All other flags keep their values.
- R4: Opcode 0xB6 ORs the mask operand into the flag word.
- R5: Opcode 0xB7 clears every flag whose mask bit is 1.
- R6: Opcode 0xB8 ANDs the mask with the flag word and does not write the result back. It then sets Z (bit 0) when the AND is zero and clears it otherwise. It sets C (bit 2) when the AND is nonzero and clears it otherwise. Every other flag keeps its value.
- R7: The halt opcode (parameter, 0xFE by default) sets H, which is bit 11, and leaves the other flags unchanged.
- R8: Bits 15..12 of the flag word always read as zero, including after mask writes with those bits set.
- R9: Without an ALU write, a cycle leaves the flag word unchanged in either case: the valid strobe is low, or the strobe carries an opcode outside 0xA0..0xB8 that is not the halt opcode.
- R10: When the ALU write-enable is high and no recognized flag opcode is present, each select bit i (0=Z, 1=N, 2=C, 3=V) that is 1 loads value bit i into flag i. Flags whose select bit is 0 keep their values.
- R11: When a recognized flag opcode and an ALU write occur in the same cycle, only the opcode takes effect and the ALU write is dropped.
- R12: Each single-flag output equals the matching bit of the flag word output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode strobe |
| opcode | input | 8 | Decoded instruction byte |
| op_mask | input | 16 | Mask operand for the mask set, clear and test opcodes |
| alu_we | input | 1 | ALU flag write-enable |
| alu_sel | input | 4 | Per-flag select for the ALU write (Z,N,C,V) |
| alu_val | input | 4 | Flag values supplied by the ALU |
| flags | output | 16 | Full flag word |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_e | output | 1 | User flag E |
| flag_f | output | 1 | User flag F |
| flag_b | output | 1 | User flag B |
| flag_u | output | 1 | User flag U |
| flag_d | output | 1 | Debug flag |
| flag_i | output | 1 | Interrupt enable flag |
| flag_s | output | 1 | Sound interrupt enable flag |
| flag_h | output | 1 | Halt flag |

## Verification
A flag opcode and an ALU flag write can arrive in the same cycle. The testbench provokes this by sweeping all 256 opcode values from several starting flag words. On alternate steps it also raises the ALU write-enable with varying select and value patterns. A reference model built from the requirements computes the next flag word. It gives precedence to recognized opcodes, and it lets the ALU write through when the opcode is unrecognized or the strobe is low. The outcome is judged by comparing the whole word and each single-flag output after every edge.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
   localparam int unsigned FLAG_Z      = 0;
   localparam int unsigned FLAG_N      = 1;
   localparam int unsigned FLAG_C      = 2;
   localparam int unsigned FLAG_V      = 3;
   localparam int unsigned FLAG_E      = 4;
   localparam int unsigned FLAG_F      = 5;
   localparam int unsigned FLAG_B      = 6;
   localparam int unsigned FLAG_U      = 7;
   localparam int unsigned FLAG_D      = 8;
   localparam int unsigned FLAG_I      = 9;
   localparam int unsigned FLAG_S      = 10;
   localparam int unsigned FLAG_H      = 11;
   localparam int unsigned NAMED_FLAGS = 11;
   localparam int unsigned IMPL_FLAGS  = 12;
   localparam int unsigned OP_SPAN     = 2 * NAMED_FLAGS + 3;

   typedef struct packed {
      logic [NAMED_FLAGS-1:0] set_one;
      logic [NAMED_FLAGS-1:0] clr_one;
      logic                   or_mask;
      logic                   clr_mask;
      logic                   test_mask;
      logic                   halt;
      logic                   hit;
   } sfu_cmd_t;
endpackage

// File: rtl/sfu_decode.sv
module sfu_decode
   import sfu_pkg::*;
#(
   parameter logic [7:0] OP_BASE = 8'hA0,
   parameter logic [7:0] HALT_OP = 8'hFE
) (
   input  logic       op_valid,
   input  logic [7:0] opcode,
   output sfu_cmd_t   cmd
);
   localparam logic [7:0] CLR_BASE = 8'(OP_BASE + NAMED_FLAGS);
   localparam logic [7:0] OR_OP    = 8'(OP_BASE + 2 * NAMED_FLAGS);
   localparam logic [7:0] ANDN_OP  = 8'(OP_BASE + 2 * NAMED_FLAGS + 1);
   localparam logic [7:0] TEST_OP  = 8'(OP_BASE + 2 * NAMED_FLAGS + 2);

   logic [NAMED_FLAGS-1:0] set_hit;
   logic [NAMED_FLAGS-1:0] clr_hit;

   for (genvar k = 0; k < NAMED_FLAGS; k++) begin : g_single
      assign set_hit[k] = op_valid && (opcode == 8'(OP_BASE + k));
      assign clr_hit[k] = op_valid && (opcode == 8'(CLR_BASE + k));
   end

   always_comb begin
      cmd           = '0;
      cmd.set_one   = set_hit;
      cmd.clr_one   = clr_hit;
      cmd.or_mask   = op_valid && (opcode == OR_OP);
      cmd.clr_mask  = op_valid && (opcode == ANDN_OP);
      cmd.test_mask = op_valid && (opcode == TEST_OP);
      cmd.halt      = op_valid && (opcode == HALT_OP);
      cmd.hit       = (|set_hit) || (|clr_hit) || cmd.or_mask ||
                      cmd.clr_mask || cmd.test_mask || cmd.halt;
   end
endmodule

// File: rtl/sfu_next.sv
module sfu_next
   import sfu_pkg::*;
#(
   parameter int unsigned FLAG_W = 16,
   parameter int unsigned ALU_W  = 4
) (
   input  logic [FLAG_W-1:0] cur,
   input  sfu_cmd_t          cmd,
   input  logic [FLAG_W-1:0] mask,
   input  logic              alu_we,
   input  logic [ALU_W-1:0]  alu_sel,
   input  logic [ALU_W-1:0]  alu_val,
   output logic [FLAG_W-1:0] nxt
);
   localparam logic [FLAG_W-1:0] IMPL_MASK =
      FLAG_W'((64'd1 << IMPL_FLAGS) - 64'd1);

   logic [ALU_W-1:0]  alu_merged;
   logic [FLAG_W-1:0] anded;
   logic [FLAG_W-1:0] w;

   for (genvar i = 0; i < ALU_W; i++) begin : g_alu_bit
      assign alu_merged[i] = alu_sel[i] ? alu_val[i] : cur[i];
   end

   assign anded = cur & mask;

   always_comb begin
      w = cur;
      if (cmd.hit) begin
         w[NAMED_FLAGS-1:0] = (w[NAMED_FLAGS-1:0] | cmd.set_one) & ~cmd.clr_one;
         if (cmd.or_mask)  w = w | mask;
         if (cmd.clr_mask) w = w & ~mask;
         if (cmd.test_mask) begin
            w[FLAG_Z] = (anded == '0);
            w[FLAG_C] = (anded != '0);
         end
         if (cmd.halt) w[FLAG_H] = 1'b1;
      end else if (alu_we) begin
         w[ALU_W-1:0] = alu_merged;
      end
      nxt = w & IMPL_MASK;
   end
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
   import sfu_pkg::*;
#(
   parameter int unsigned FLAG_W  = 16,
   parameter int unsigned ALU_W   = 4,
   parameter logic [7:0]  OP_BASE = 8'hA0,
   parameter logic [7:0]  HALT_OP = 8'hFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [7:0]        opcode,
   input  logic [FLAG_W-1:0] op_mask,
   input  logic              alu_we,
   input  logic [ALU_W-1:0]  alu_sel,
   input  logic [ALU_W-1:0]  alu_val,
   output logic [FLAG_W-1:0] flags,
   output logic              flag_z,
   output logic              flag_n,
   output logic              flag_c,
   output logic              flag_v,
   output logic              flag_e,
   output logic              flag_f,
   output logic              flag_b,
   output logic              flag_u,
   output logic              flag_d,
   output logic              flag_i,
   output logic              flag_s,
   output logic              flag_h
);
   localparam int unsigned OP_LAST = OP_BASE + OP_SPAN - 1;

   if (FLAG_W < IMPL_FLAGS) begin : g_bad_width
      $error("status_flag_unit: FLAG_W must hold all implemented flags");
   end
   if (ALU_W < 1 || ALU_W > 4) begin : g_bad_alu
      $error("status_flag_unit: ALU_W must be 1..4");
   end
   if (OP_LAST > 255) begin : g_bad_base
      $error("status_flag_unit: opcode block overflows the byte");
   end
   if (HALT_OP >= OP_BASE && int'(HALT_OP) <= OP_LAST) begin : g_bad_halt
      $error("status_flag_unit: halt opcode collides with flag opcodes");
   end

   sfu_cmd_t          cmd;
   logic [FLAG_W-1:0] flag_d_next;
   logic [FLAG_W-1:0] flag_q;

   sfu_decode #(
      .OP_BASE (OP_BASE),
      .HALT_OP (HALT_OP)
   ) u_decode (
      .op_valid (op_valid),
      .opcode   (opcode),
      .cmd      (cmd)
   );

   sfu_next #(
      .FLAG_W (FLAG_W),
      .ALU_W  (ALU_W)
   ) u_next (
      .cur     (flag_q),
      .cmd     (cmd),
      .mask    (op_mask),
      .alu_we  (alu_we),
      .alu_sel (alu_sel),
      .alu_val (alu_val),
      .nxt     (flag_d_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag_d_next;
   end

   assign flags  = flag_q;
   assign flag_z = flag_q[FLAG_Z];
   assign flag_n = flag_q[FLAG_N];
   assign flag_c = flag_q[FLAG_C];
   assign flag_v = flag_q[FLAG_V];
   assign flag_e = flag_q[FLAG_E];
   assign flag_f = flag_q[FLAG_F];
   assign flag_b = flag_q[FLAG_B];
   assign flag_u = flag_q[FLAG_U];
   assign flag_d = flag_q[FLAG_D];
   assign flag_i = flag_q[FLAG_I];
   assign flag_s = flag_q[FLAG_S];
   assign flag_h = flag_q[FLAG_H];
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
   parameter int unsigned FLAG_W  = 16,
   parameter int unsigned ALU_W   = 4,
   parameter logic [7:0]  OP_BASE = 8'hA0,
   parameter logic [7:0]  HALT_OP = 8'hFE
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [7:0]        opcode,
   input logic [FLAG_W-1:0] op_mask,
   input logic              alu_we,
   input logic [ALU_W-1:0]  alu_sel,
   input logic [ALU_W-1:0]  alu_val,
   input logic [FLAG_W-1:0] flags,
   input logic              flag_z,
   input logic              flag_c,
   input logic              flag_h
);
   localparam logic [7:0] OR_OP   = 8'(OP_BASE + 22);
   localparam logic [7:0] ANDN_OP = 8'(OP_BASE + 23);
   localparam logic [7:0] TEST_OP = 8'(OP_BASE + 24);
   localparam logic [FLAG_W-1:0] IMPL = FLAG_W'(16'h0FFF);

   logic unknown_op;
   assign unknown_op = !op_valid || ((opcode < OP_BASE || opcode > TEST_OP) &&
                                     opcode != HALT_OP);

   a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (flags == '0) || !rst_n);

   a_r4_mask_or: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && opcode == OR_OP |=> flags == ($past(flags | op_mask) & IMPL));

   a_r5_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && opcode == ANDN_OP |=> flags == ($past(flags & ~op_mask) & IMPL));

   a_r6_test_zc: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && opcode == TEST_OP |=>
         (flag_z == ($past(flags & op_mask) == '0)) && (flag_c != flag_z));

   a_r7_halt_set: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && opcode == HALT_OP |=> flag_h);

   a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (flags & ~IMPL) == '0);

   a_r9_unknown_stable: assert property (@(posedge clk) disable iff (!rst_n)
      unknown_op && !alu_we |=> $stable(flags));

   a_r10_alu_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
      unknown_op && alu_we && alu_sel[0] |=> flag_z == $past(alu_val[0]));

   a_r11_opcode_wins: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && opcode == OP_BASE && alu_we |=> flag_z);
endmodule

bind status_flag_unit sfu_checker #(
   .FLAG_W  (FLAG_W),
   .ALU_W   (ALU_W),
   .OP_BASE (OP_BASE),
   .HALT_OP (HALT_OP)
) u_sfu_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .opcode   (opcode),
   .op_mask  (op_mask),
   .alu_we   (alu_we),
   .alu_sel  (alu_sel),
   .alu_val  (alu_val),
   .flags    (flags),
   .flag_z   (flag_z),
   .flag_c   (flag_c),
   .flag_h   (flag_h)
);

// File: tb/status_flag_unit_tb.sv
module status_flag_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [7:0]  opcode = '0;
   logic [15:0] op_mask = '0;
   logic        alu_we = 1'b0;
   logic [3:0]  alu_sel = '0;
   logic [3:0]  alu_val = '0;
   logic [15:0] flags;
   logic flag_z, flag_n, flag_c, flag_v, flag_e, flag_f;
   logic flag_b, flag_u, flag_d, flag_i, flag_s, flag_h;

   int checks = 0;
   int fails  = 0;
   logic [15:0] model = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   status_flag_unit u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
      .op_mask(op_mask), .alu_we(alu_we), .alu_sel(alu_sel), .alu_val(alu_val),
      .flags(flags), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c),
      .flag_v(flag_v), .flag_e(flag_e), .flag_f(flag_f), .flag_b(flag_b),
      .flag_u(flag_u), .flag_d(flag_d), .flag_i(flag_i), .flag_s(flag_s),
      .flag_h(flag_h)
   );

   function automatic logic recognized(input logic v, input logic [7:0] op);
      return v && ((op >= 8'hA0 && op <= 8'hB8) || op == 8'hFE);
   endfunction

   function automatic logic [15:0] ref_next(input logic [15:0] cur, input logic v,
         input logic [7:0] op, input logic [15:0] m, input logic we,
         input logic [3:0] sel, input logic [3:0] val);
      logic [15:0] n;
      n = cur;
      if (recognized(v, op)) begin
         if (op <= 8'hAA)       n[op - 8'hA0] = 1'b1;
         else if (op <= 8'hB5)  n[op - 8'hAB] = 1'b0;
         else if (op == 8'hB6)  n = cur | m;
         else if (op == 8'hB7)  n = cur & ~m;
         else if (op == 8'hB8) begin
            n[0] = ((cur & m) == 16'h0);
            n[2] = ((cur & m) != 16'h0);
         end else               n[11] = 1'b1;
      end else if (we) begin
         for (int i = 0; i < 4; i++) if (sel[i]) n[i] = val[i];
      end
      return n & 16'h0FFF;
   endfunction

   function automatic string tag(input logic v, input logic [7:0] op, input logic we);
      if (!recognized(v, op)) return we ? "R10" : "R9";
      if (we) return "R11";
      if (op <= 8'hAA) return "R2";
      if (op <= 8'hB5) return "R3";
      if (op == 8'hB6) return "R4";
      if (op == 8'hB7) return "R5";
      if (op == 8'hB8) return "R6";
      return "R7";
   endfunction

   task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_outputs(input string req);
      logic [15:0] bits;
      bits = {4'h0, flag_h, flag_s, flag_i, flag_d, flag_u, flag_b, flag_f,
              flag_e, flag_v, flag_c, flag_n, flag_z};
      check16(req, flags, model);
      check16("R8", flags & 16'hF000, 16'h0000);
      check16("R12", bits, flags & 16'h0FFF);
   endtask

   task automatic step(input logic v, input logic [7:0] op, input logic [15:0] m,
                       input logic we, input logic [3:0] sel, input logic [3:0] val);
      string req;
      @(negedge clk);
      op_valid = v; opcode = op; op_mask = m;
      alu_we = we; alu_sel = sel; alu_val = val;
      req = tag(v, op, we);
      model = ref_next(model, v, op, m, we, sel, val);
      @(posedge clk);
      #1;
      check_outputs(req);
      @(negedge clk);
      op_valid = 1'b0; alu_we = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      model = '0;
      check_outputs("R1");
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] starts [4];
      starts[0] = 16'h0000; starts[1] = 16'hFFFF;
      starts[2] = 16'h0A5A; starts[3] = 16'hF5A5;

      #(CLK_PERIOD * 2 + 1);
      check_outputs("R1");
      rst_n = 1'b1;

      // sweep every opcode from several starting words, ALU write on odd steps
      for (int s = 0; s < 4; s++) begin
         for (int op = 0; op < 256; op++) begin
            step(1'b1, 8'hB7, 16'hFFFF, 1'b0, 4'h0, 4'h0);
            step(1'b1, 8'hB6, starts[s], 1'b0, 4'h0, 4'h0);
            step(1'b1, 8'(op), 16'(op * 16'h0101) ^ starts[s] ^ 16'(s * 16'h3C3C),
                 op[0], 4'(op >> 1), 4'(op * 3 + s));
         end
      end

      // single-flag opcodes in order, one at a time from zero and from all-ones (R2, R3)
      for (int k = 0; k < 11; k++) begin
         step(1'b1, 8'hB7, 16'hFFFF, 1'b0, 4'h0, 4'h0);
         step(1'b1, 8'(8'hA0 + k), 16'h0000, 1'b0, 4'h0, 4'h0);
         check16("R2", flags, 16'(1 << k));
         step(1'b1, 8'hB6, 16'h07FF, 1'b0, 4'h0, 4'h0);
         step(1'b1, 8'(8'hAB + k), 16'h0000, 1'b0, 4'h0, 4'h0);
         check16("R3", flags, 16'h07FF & ~16'(1 << k));
      end

      // mask test corner: all-zero mask and full mask (R6)
      step(1'b1, 8'hB8, 16'h0000, 1'b0, 4'h0, 4'h0);
      check16("R6", {15'h0, flag_z}, 16'h1);
      step(1'b1, 8'hB6, 16'h0F00, 1'b0, 4'h0, 4'h0);
      step(1'b1, 8'hB8, 16'h0100, 1'b0, 4'h0, 4'h0);
      check16("R6", {14'h0, flag_c, flag_z}, 16'h2);

      // ALU select sweep with strobe low (R10) and with an unknown opcode
      for (int sel = 0; sel < 16; sel++) begin
         for (int val = 0; val < 16; val += 5) begin
            step(1'b0, 8'hA0, 16'h0, 1'b1, 4'(sel), 4'(val));
            step(1'b1, 8'h12, 16'hFFFF, 1'b1, 4'(~sel), 4'(~val));
         end
      end

      // halt then reset mid-run (R7, R1)
      step(1'b1, 8'hFE, 16'h0000, 1'b1, 4'hF, 4'h0);
      check16("R7", {15'h0, flag_h}, 16'h1);
      do_reset();
      step(1'b0, 8'h00, 16'h0, 1'b0, 4'h0, 4'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule